// File: doc/BRIEF.md
# Serial Receiver with Shared Line Status Flag

This block turns an asynchronous serial RX line into parallel words. It runs from the core clock and uses an oversampling tick at sixteen times the bit rate. It finds the falling edge of a start bit and confirms that bit at its centre. It then samples each following bit at its centre: the data bits first, then a parity bit if one is enabled, then one stop bit. Each correctly framed word goes into a small first-word-fall-through queue together with its received parity bit. A host pops words from that queue.

One status output, `line_flag`, has two meanings that depend on the operating mode. In normal mode it is a sticky framing-error flag. It is set when the stop bit is found low, and it is cleared either by the next correctly framed word or by a configuration write. In shutdown mode the frame engine is held idle, and any transition on the RX line sets the flag. The host can therefore use it as a wake-up indicator.

Top module: `uart_rx_frm`

## Requirements
- R1: A low pulse on the RX line that is no longer low at the half-bit point (8 ticks after the falling edge) is discarded as a glitch. No word is queued.
- R2: With `cfg_short`=0 the receiver takes 8 data bits, least significant bit first. The word appears on `rd_data[7:0]`.
- R3: With `cfg_short`=1 the receiver takes 7 data bits, least significant bit first, into `rd_data[6:0]`. `rd_data[7]` is 0, and the bit that follows the seventh bit is treated as the next field.
- R4: With `cfg_parity_en`=1, the bit after the data is stored and shown on `rd_parity`. With `cfg_parity_en`=0 the stop bit follows the data directly and `rd_parity` reads 0.
- R5: A low level at the centre of the first stop bit is a framing error. It sets `line_flag`, queues no word, and returns the receiver to waiting for a new falling edge.
- R6: Once set by a framing error, `line_flag` stays set through queue reads. The next correctly framed word clears it.
- R7: A one-cycle `cfg_write` pulse clears `line_flag`. If a setting event occurs in the same cycle, the setting event wins.
- R8: Only one stop bit is checked. A frame that starts straight after a single stop bit is received, and so is a frame sent with two stop bits.
- R9: While `shutdown_mode`=1, every rising or falling transition on the RX line sets `line_flag`, and no word is queued.
- R10: The queue holds `FIFO_DEPTH` words (4 by default) in arrival order, with the head word visible on `rd_data`. A word that arrives while the queue is full is dropped and raises `overrun` for one cycle. A pop while the queue is empty has no effect.
- R11: After reset the queue is empty and not full, and `line_flag` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_short | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_parity_en | input | 1 | 1 expects a parity bit after the data |
| cfg_write | input | 1 | One-cycle configuration write strobe; clears the flag |
| shutdown_mode | input | 1 | 1 holds the receiver idle and makes the flag an activity detector |
| fifo_rd | input | 1 | Pops the head word of the queue |
| rd_data | output | 8 | Head word of the queue |
| rd_parity | output | 1 | Parity bit stored with the head word |
| fifo_empty | output | 1 | Queue holds no word |
| fifo_full | output | 1 | Queue holds `FIFO_DEPTH` words |
| overrun | output | 1 | One-cycle pulse when an arriving word is dropped |
| line_flag | output | 1 | Framing-error flag in normal mode, activity flag in shutdown mode |

## Verification
The assertions take for granted that `cfg_write` and `fifo_rd` are single-cycle strobes. They also assume that `shutdown_mode` changes only while no frame is in flight, so a word being completed cannot coincide with entering shutdown. The stimulus drives every input at the falling clock edge. It changes mode and configuration only when the line has been idle for at least a bit time. It keeps the bit period at exactly 16 ticks, so each sample lands near the centre of its bit.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [2:0] {
        RXS_IDLE,
        RXS_START,
        RXS_DATA,
        RXS_PAR,
        RXS_STOP
    } rxs_state_e;

endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_s,
    output logic rx_fall,
    output logic rx_edge
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], rx_in};
        sync_d.prev  = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rx_s    = sync_q.chain[STAGES-1];
    assign rx_fall = sync_q.prev & ~rx_s;
    assign rx_edge = sync_q.prev ^ rx_s;

endmodule

// File: rtl/rxf_frame.sv
module rxf_frame
    import rxf_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic              rx_fall,
    input  logic              hold,
    input  logic              short_word,
    input  logic              par_en,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              push_par,
    output logic              frm_ok,
    output logic              frm_err
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DATA_W);
    localparam logic [CW-1:0] MID_C  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] FULL_C = CW'(OSR - 1);
    localparam logic [CW-1:0] CNT1_C = CW'(1);
    localparam logic [IW-1:0] LONG_C = IW'(DATA_W - 1);
    localparam logic [IW-1:0] SHRT_C = IW'(DATA_W - 2);
    localparam logic [IW-1:0] IDX1_C = IW'(1);

    typedef struct packed {
        rxs_state_e        state;
        logic [CW-1:0]     cnt;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] data;
        logic              par;
        logic              short_w;
        logic              pen;
        logic              push;
        logic              ok;
        logic              err;
    } frame_t;

    frame_t fr_d, fr_q;
    logic [IW-1:0] last_idx;

    assign last_idx = fr_q.short_w ? SHRT_C : LONG_C;

    always_comb begin
        fr_d      = fr_q;
        fr_d.push = 1'b0;
        fr_d.ok   = 1'b0;
        fr_d.err  = 1'b0;
        if (hold) begin
            fr_d.state = RXS_IDLE;
            fr_d.cnt   = '0;
        end else begin
            unique case (fr_q.state)
                RXS_IDLE: begin
                    if (rx_fall) begin
                        fr_d.state   = RXS_START;
                        fr_d.cnt     = '0;
                        fr_d.idx     = '0;
                        fr_d.data    = '0;
                        fr_d.par     = 1'b0;
                        fr_d.short_w = short_word;
                        fr_d.pen     = par_en;
                    end
                end
                RXS_START: begin
                    if (tick) begin
                        if (fr_q.cnt == MID_C) begin
                            fr_d.cnt   = '0;
                            fr_d.state = rx_s ? RXS_IDLE : RXS_DATA;
                        end else begin
                            fr_d.cnt = fr_q.cnt + CNT1_C;
                        end
                    end
                end
                RXS_DATA: begin
                    if (tick) begin
                        if (fr_q.cnt == FULL_C) begin
                            fr_d.cnt = '0;
                            fr_d.data[fr_q.idx] = rx_s;
                            if (fr_q.idx == last_idx) begin
                                fr_d.idx   = '0;
                                fr_d.state = fr_q.pen ? RXS_PAR : RXS_STOP;
                            end else begin
                                fr_d.idx = fr_q.idx + IDX1_C;
                            end
                        end else begin
                            fr_d.cnt = fr_q.cnt + CNT1_C;
                        end
                    end
                end
                RXS_PAR: begin
                    if (tick) begin
                        if (fr_q.cnt == FULL_C) begin
                            fr_d.cnt   = '0;
                            fr_d.par   = rx_s;
                            fr_d.state = RXS_STOP;
                        end else begin
                            fr_d.cnt = fr_q.cnt + CNT1_C;
                        end
                    end
                end
                RXS_STOP: begin
                    if (tick) begin
                        if (fr_q.cnt == FULL_C) begin
                            fr_d.cnt   = '0;
                            fr_d.state = RXS_IDLE;
                            fr_d.push  = rx_s;
                            fr_d.ok    = rx_s;
                            fr_d.err   = ~rx_s;
                        end else begin
                            fr_d.cnt = fr_q.cnt + CNT1_C;
                        end
                    end
                end
                default: fr_d.state = RXS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign push      = fr_q.push;
    assign push_data = fr_q.data;
    assign push_par  = fr_q.par;
    assign frm_ok    = fr_q.ok;
    assign frm_err   = fr_q.err;

endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full,
    output logic         overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);
    localparam logic [AW-1:0] PTR1_C  = AW'(1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [CW-1:0] CNT1_C  = CW'(1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovr;
    } fifo_t;

    fifo_t ff_d, ff_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty   = (ff_q.cnt == '0);
    assign full    = (ff_q.cnt == CNT_MAX);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;

    always_comb begin
        ff_d     = ff_q;
        ff_d.ovr = push & full;
        if (do_push) begin
            ff_d.wp = (ff_q.wp == PTR_MAX) ? '0 : ff_q.wp + PTR1_C;
        end
        if (do_pop) begin
            ff_d.rp = (ff_q.rp == PTR_MAX) ? '0 : ff_q.rp + PTR1_C;
        end
        if (do_push && !do_pop) begin
            ff_d.cnt = ff_q.cnt + CNT1_C;
        end else if (do_pop && !do_push) begin
            ff_d.cnt = ff_q.cnt - CNT1_C;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff_q <= '0;
        end else begin
            ff_q <= ff_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[ff_q.wp] <= wdata;
        end
    end

    assign rdata   = mem_q[ff_q.rp];
    assign overrun = ff_q.ovr;

endmodule

// File: rtl/uart_rx_frm.sv
module uart_rx_frm #(
    parameter int OSR        = 16,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_line,
    input  logic              cfg_short,
    input  logic              cfg_parity_en,
    input  logic              cfg_write,
    input  logic              shutdown_mode,
    input  logic              fifo_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_parity,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              overrun,
    output logic              line_flag
);
    localparam int EW = DATA_W + 1;

    logic rx_s, rx_fall, rx_edge;
    logic push, push_par, frm_ok, frm_err, act_evt;
    logic [DATA_W-1:0] push_data;
    logic [EW-1:0] head;
    logic flag_d, flag_q;

    rxf_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_in   (rx_line),
        .rx_s    (rx_s),
        .rx_fall (rx_fall),
        .rx_edge (rx_edge)
    );

    rxf_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .rx_s       (rx_s),
        .rx_fall    (rx_fall),
        .hold       (shutdown_mode),
        .short_word (cfg_short),
        .par_en     (cfg_parity_en),
        .push       (push),
        .push_data  (push_data),
        .push_par   (push_par),
        .frm_ok     (frm_ok),
        .frm_err    (frm_err)
    );

    rxf_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .wdata   ({push_par, push_data}),
        .pop     (fifo_rd),
        .rdata   (head),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .overrun (overrun)
    );

    assign act_evt = shutdown_mode & rx_edge;

    always_comb begin
        flag_d = flag_q;
        if (cfg_write || frm_ok) begin
            flag_d = 1'b0;
        end
        if (frm_err || act_evt) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign rd_data   = head[DATA_W-1:0];
    assign rd_parity = head[DATA_W];
    assign line_flag = flag_q;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_write,
    input logic shutdown_mode,
    input logic fifo_full,
    input logic fifo_empty,
    input logic overrun,
    input logic line_flag,
    input logic push,
    input logic frm_ok,
    input logic frm_err,
    input logic act_evt
);
    // R10
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R10
    ovr_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(fifo_full));

    // R5
    fe_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err |=> line_flag);

    // R5
    ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_ok && frm_err));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_flag && !cfg_write && !frm_ok) |=> line_flag);

    // R6
    ok_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_ok && !act_evt) |=> !line_flag);

    // R7
    cfg_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_write && !frm_err && !act_evt) |=> !line_flag);

    // R9
    act_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_evt |=> line_flag);

    // R9
    shdn_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_mode && $past(shutdown_mode)) |-> !push);

endmodule

bind uart_rx_frm rxf_checker u_rxf_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_write     (cfg_write),
    .shutdown_mode (shutdown_mode),
    .fifo_full     (fifo_full),
    .fifo_empty    (fifo_empty),
    .overrun       (overrun),
    .line_flag     (line_flag),
    .push          (push),
    .frm_ok        (frm_ok),
    .frm_err       (frm_err),
    .act_evt       (act_evt)
);

// File: tb/test_uart_rx_frm.sv
module test_uart_rx_frm;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;
    localparam int DEPTH      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b0;
    logic rx_line = 1'b1;
    logic cfg_short = 1'b0;
    logic cfg_parity_en = 1'b0;
    logic cfg_write = 1'b0;
    logic shutdown_mode = 1'b0;
    logic fifo_rd = 1'b0;
    logic [7:0] rd_data;
    logic rd_parity, fifo_empty, fifo_full, overrun, line_flag;

    int compared = 0;
    int mismatched = 0;
    int ovr_seen = 0;
    bit finished = 1'b0;

    uart_rx_frm i_uart_rx_frm (
        .clk           (clk),
        .rst_n         (rst_n),
        .os_tick       (os_tick),
        .rx_line       (rx_line),
        .cfg_short     (cfg_short),
        .cfg_parity_en (cfg_parity_en),
        .cfg_write     (cfg_write),
        .shutdown_mode (shutdown_mode),
        .fifo_rd       (fifo_rd),
        .rd_data       (rd_data),
        .rd_parity     (rd_parity),
        .fifo_empty    (fifo_empty),
        .fifo_full     (fifo_full),
        .overrun       (overrun),
        .line_flag     (line_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        os_tick <= ~os_tick;
        if (rst_n && overrun) ovr_seen <= ovr_seen + 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] data, input logic short_w,
                              input logic pen, input logic par,
                              input logic stop_ok, input int nstop);
        int nb;
        cfg_short = short_w;
        cfg_parity_en = pen;
        nb = short_w ? 7 : 8;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(data[i]);
        if (pen) drive_bit(par);
        drive_bit(stop_ok);
        if (nstop == 2) drive_bit(1'b1);
        if (!stop_ok) drive_bit(1'b1);
        rx_line = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pop_word();
        fifo_rd = 1'b1;
        @(negedge clk);
        fifo_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_cfg();
        cfg_write = 1'b1;
        @(negedge clk);
        cfg_write = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11", "empty", fifo_empty, 1);
        chk("R11", "full", fifo_full, 0);
        chk("R11", "flag", line_flag, 0);
        chk("R11", "overrun", overrun, 0);
    endtask

    task automatic t_eight();
        send_frame(8'hA5, 0, 0, 0, 1, 1);
        chk("R2", "data A5", rd_data, 8'hA5);
        chk("R4", "parity off", rd_parity, 0);
        pop_word();
        send_frame(8'h3C, 0, 0, 0, 1, 1);
        chk("R2", "data 3C", rd_data, 8'h3C);
        pop_word();
        chk("R2", "empty after pops", fifo_empty, 1);
    endtask

    task automatic t_seven();
        send_frame(8'h2D, 1, 0, 0, 1, 1);
        chk("R3", "7-bit data", rd_data, 8'h2D);
        pop_word();
        send_frame(8'h7F, 1, 0, 0, 1, 1);
        chk("R3", "7-bit msb zero", rd_data, 8'h7F);
        pop_word();
    endtask

    task automatic t_parity();
        send_frame(8'h81, 0, 1, 1, 1, 1);
        chk("R4", "data with parity", rd_data, 8'h81);
        chk("R4", "parity 1", rd_parity, 1);
        pop_word();
        send_frame(8'h81, 0, 1, 0, 1, 1);
        chk("R4", "parity 0", rd_parity, 0);
        pop_word();
        send_frame(8'h40, 1, 1, 1, 1, 1);
        chk("R4", "7-bit + parity data", rd_data, 8'h40);
        chk("R4", "7-bit + parity bit", rd_parity, 1);
        pop_word();
    endtask

    task automatic t_glitch();
        rx_line = 1'b0;
        repeat (10) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        chk("R1", "glitch queued nothing", fifo_empty, 1);
        send_frame(8'h5E, 0, 0, 0, 1, 1);
        chk("R1", "next frame after glitch", rd_data, 8'h5E);
        pop_word();
    endtask

    task automatic t_frame_err();
        send_frame(8'h11, 0, 0, 0, 1, 1);
        send_frame(8'h55, 0, 0, 0, 0, 1);
        chk("R5", "flag set", line_flag, 1);
        chk("R5", "head still 11", rd_data, 8'h11);
        pop_word();
        chk("R5", "bad word not queued", fifo_empty, 1);
        chk("R6", "flag kept after read", line_flag, 1);
        send_frame(8'h22, 0, 0, 0, 1, 1);
        chk("R6", "good frame clears flag", line_flag, 0);
        chk("R5", "receiver resumed", rd_data, 8'h22);
        pop_word();
    endtask

    task automatic t_cfg_clear();
        send_frame(8'h0F, 0, 0, 0, 0, 1);
        chk("R7", "flag set before write", line_flag, 1);
        pulse_cfg();
        chk("R7", "cfg write cleared flag", line_flag, 0);
        chk("R7", "fifo untouched", fifo_empty, 1);
    endtask

    task automatic t_back2back();
        cfg_short = 0;
        cfg_parity_en = 0;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(1'(8'h01 >> i));
        drive_bit(1'b1);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(1'(8'hFE >> i));
        drive_bit(1'b1);
        repeat (4) @(negedge clk);
        chk("R8", "first of pair", rd_data, 8'h01);
        pop_word();
        chk("R8", "second of pair", rd_data, 8'hFE);
        pop_word();
        send_frame(8'hC3, 0, 0, 0, 1, 2);
        chk("R8", "two stop bits", rd_data, 8'hC3);
        pop_word();
        chk("R8", "flag clean", line_flag, 0);
    endtask

    task automatic t_fifo();
        int base;
        base = ovr_seen;
        for (int k = 0; k < DEPTH + 1; k++) begin
            send_frame(8'(8'h60 + k), 0, 0, 0, 1, 1);
        end
        chk("R10", "full", fifo_full, 1);
        chk("R10", "one overrun pulse", ovr_seen - base, 1);
        chk("R10", "overrun low after", overrun, 0);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R10", "order", rd_data, 8'(8'h60 + k));
            pop_word();
        end
        chk("R10", "empty after drain", fifo_empty, 1);
        pop_word();
        chk("R10", "pop on empty", fifo_empty, 1);
        send_frame(8'h9A, 0, 0, 0, 1, 1);
        chk("R10", "word after empty pop", rd_data, 8'h9A);
        pop_word();
        chk("R10", "single word drained", fifo_empty, 1);
    endtask

    task automatic t_shutdown();
        shutdown_mode = 1'b1;
        repeat (4) @(negedge clk);
        pulse_cfg();
        chk("R9", "flag clear in shutdown", line_flag, 0);
        rx_line = 1'b0;
        repeat (6) @(negedge clk);
        chk("R9", "fall sets flag", line_flag, 1);
        rx_line = 1'b1;
        repeat (6) @(negedge clk);
        pulse_cfg();
        chk("R7", "cfg clears in shutdown", line_flag, 0);
        rx_line = 1'b0;
        repeat (3) @(negedge clk);
        rx_line = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9", "short pulse sets flag", line_flag, 1);
        send_frame(8'h00, 0, 0, 0, 1, 1);
        chk("R9", "no word in shutdown", fifo_empty, 1);
        shutdown_mode = 1'b0;
        repeat (4) @(negedge clk);
        pulse_cfg();
        send_frame(8'hB7, 0, 0, 0, 1, 1);
        chk("R9", "normal after exit", rd_data, 8'hB7);
        chk("R9", "flag normal after exit", line_flag, 0);
        pop_word();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_eight();
        t_seven();
        t_parity();
        t_glitch();
        t_frame_err();
        t_cfg_clear();
        t_back2back();
        t_fifo();
        t_shutdown();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule